// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block models the command side of a NOR flash device as seen from its host bus. It watches single-cycle write strobes on an address/data bus and decodes the unlock-and-command sequence for a whole-array erase. Once that sequence is accepted, an internal routine takes over. It first drives every word of a small register array to zero and verifies each one. It then sets every word to all ones. The host supplies no further control during this time. It can follow progress on the ready/busy pin or by polling status bits on reads.

A short word-program sequence is also decoded, so the host can load known data before an erase. Programming can only clear bits. A hardware reset stops a running erase at once and leaves the array in whatever partial state it had reached. The host must then issue the erase sequence again.

Write and read strobes are plain one-cycle pulses. There is no back-pressure: every strobe is taken in the cycle it is high. While the routine runs, writes are dropped and reads return status instead of array data.

Top module: `flash_ce_top`

## Requirements
- R1: An erase starts only after six consecutive writes, matched on the low 11 address bits and the low 8 data bits: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, 0x10 at 0x555.
- R2: A write that does not match the next expected step returns the decoder to idle and is discarded. This holds even when that write would itself be a valid first step. No erase or program follows from a broken sequence.
- R3: `ready_busy_n` is still high in the cycle after the clock edge that samples the final erase write, and goes low one cycle later. It stays low for exactly WORDS*(PRE_CLKS+1) + WORDS*ERS_CLKS cycles.
- R4: The routine first writes zero to each word in ascending index order and verifies it. Each word takes PRE_CLKS write cycles plus one verify cycle. Only then does it start setting words to all ones, taking ERS_CLKS cycles per word.
- R5: After the routine completes, every word reads as all ones (0xFFFF for 16-bit data).
- R6: Writes issued while busy are ignored. A repeated erase sequence does not restart or stretch the busy interval, and a program sequence changes no word.
- R7: Reset deasserts busy immediately. Reads then return array contents, which reflect the partial work done so far. A fresh erase sequence afterwards runs in full.
- R8: While busy, a read returns bit 7 = 0, with bits 6 and 2 equal to each other and all other bits 0. Bits 6 and 2 read 0 on the first read after the erase starts and invert on each later read.
- R9: With `bus_oe` low, `bus_rdata` is zero.
- R10: The writes 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, followed by one write of data D at address A, set word A[IW-1:0] to its old value AND D.
- R11: When not busy, a read returns the array word selected by the low IW address bits.
- R12: After reset, `ready_busy_n` is high and no command sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset; aborts a running erase |
| bus_addr | input | AW | Word address for writes and reads |
| bus_wdata | input | DW | Write data / command byte in the low 8 bits |
| bus_we | input | 1 | One-cycle write strobe |
| bus_oe | input | 1 | Read strobe |
| bus_rdata | output | DW | Array word or status; zero when `bus_oe` is low |
| ready_busy_n | output | 1 | High when ready, low while the erase routine runs |

## Verification
The bench builds the block with WORDS=8, PRE_CLKS=3 and ERS_CLKS=5. This gives a busy window of 72 cycles, so the exact busy length can be counted on every erase run. A complete erase sequence and a program sequence can be issued inside that window to show they are dropped. The short per-word timing also lets a reset land partway through the zero-fill phase. The words already zeroed and the words not yet reached can then both be read back.

// File: rtl/flash_ce_pkg.sv
package flash_ce_pkg;

  localparam logic [10:0] UNLOCK_ADDR_A   = 11'h555;
  localparam logic [10:0] UNLOCK_ADDR_B   = 11'h2AA;
  localparam logic [7:0]  KEY_A           = 8'hAA;
  localparam logic [7:0]  KEY_B           = 8'h55;
  localparam logic [7:0]  KEY_ERASE_SETUP = 8'h80;
  localparam logic [7:0]  KEY_CHIP_ERASE  = 8'h10;
  localparam logic [7:0]  KEY_PROGRAM     = 8'hA0;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_K1,
    CS_K2,
    CS_SETUP,
    CS_K3,
    CS_K4,
    CS_PROG
  } cmd_state_t;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_PRE_WR,
    EN_PRE_VF,
    EN_ERS_WR
  } eng_state_t;

endpackage

// File: rtl/flash_ce_cmd.sv
module flash_ce_cmd
  import flash_ce_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic          start_erase,
  output logic          prog_req,
  output logic [IW-1:0] prog_idx,
  output logic [DW-1:0] prog_data
);

  cmd_state_t cur, nxt;
  logic hit_a, hit_b;
  logic [7:0] key;
  logic erase_fire, prog_fire;

  assign hit_a = (addr[10:0] == UNLOCK_ADDR_A);
  assign hit_b = (addr[10:0] == UNLOCK_ADDR_B);
  assign key   = wdata[7:0];

  always_comb begin
    nxt        = cur;
    erase_fire = 1'b0;
    prog_fire  = 1'b0;
    if (busy) begin
      nxt = CS_IDLE;
    end else if (we) begin
      nxt = CS_IDLE;
      unique case (cur)
        CS_IDLE:  if (hit_a && key == KEY_A) nxt = CS_K1;
        CS_K1:    if (hit_b && key == KEY_B) nxt = CS_K2;
        CS_K2: begin
          if (hit_a && key == KEY_ERASE_SETUP) nxt = CS_SETUP;
          else if (hit_a && key == KEY_PROGRAM) nxt = CS_PROG;
        end
        CS_SETUP: if (hit_a && key == KEY_A) nxt = CS_K3;
        CS_K3:    if (hit_b && key == KEY_B) nxt = CS_K4;
        CS_K4:    if (hit_a && key == KEY_CHIP_ERASE) erase_fire = 1'b1;
        CS_PROG:  prog_fire = 1'b1;
        default:  nxt = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur         <= CS_IDLE;
      start_erase <= 1'b0;
      prog_req    <= 1'b0;
      prog_idx    <= '0;
      prog_data   <= '0;
    end else begin
      cur         <= nxt;
      start_erase <= erase_fire;
      prog_req    <= prog_fire;
      if (prog_fire) begin
        prog_idx  <= addr[IW-1:0];
        prog_data <= wdata;
      end
    end
  end

  // R1
  erase_after_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_erase |-> $past(cur) == CS_K4);

  // R6
  busy_drops_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!start_erase && !prog_req));

endmodule

// File: rtl/flash_ce_array.sv
module flash_ce_array #(
  parameter int WORDS = 16,
  parameter int DW    = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_and,
  input  logic [IW-1:0] rd_idx_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] cells [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IW'(g)) begin
        word_q <= wr_and ? (word_q & wr_data) : wr_data;
      end
    end
    assign cells[g] = word_q;
  end

  assign rd_a = cells[rd_idx_a];
  assign rd_b = cells[rd_idx_b];

endmodule

// File: rtl/flash_ce_engine.sv
module flash_ce_engine
  import flash_ce_pkg::*;
#(
  parameter int WORDS    = 16,
  parameter int DW       = 16,
  parameter int IW       = 4,
  parameter int PRE_CLKS = 4,
  parameter int ERS_CLKS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] vf_word,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          wr_en,
  output logic [DW-1:0] wr_fill
);

  localparam int CMAX = (PRE_CLKS > ERS_CLKS) ? PRE_CLKS : ERS_CLKS;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX + 1) : 1;
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CLKS - 1);
  localparam logic [CW-1:0] ERS_LAST = CW'(ERS_CLKS - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(WORDS - 1);

  eng_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= EN_IDLE;
      cnt <= '0;
      idx <= '0;
    end else begin
      unique case (st)
        EN_IDLE: begin
          if (start) begin
            st  <= EN_PRE_WR;
            cnt <= '0;
            idx <= '0;
          end
        end
        EN_PRE_WR: begin
          if (cnt == PRE_LAST) begin
            cnt <= '0;
            st  <= EN_PRE_VF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EN_PRE_VF: begin
          if (vf_word == '0) begin
            if (idx == IDX_LAST) begin
              idx <= '0;
              st  <= EN_ERS_WR;
            end else begin
              idx <= idx + 1'b1;
              st  <= EN_PRE_WR;
            end
          end else begin
            st <= EN_PRE_WR;
          end
        end
        EN_ERS_WR: begin
          if (cnt == ERS_LAST) begin
            cnt <= '0;
            if (idx == IDX_LAST) begin
              idx <= '0;
              st  <= EN_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  assign busy    = (st != EN_IDLE);
  assign wr_en   = (st == EN_PRE_WR && cnt == PRE_LAST) ||
                   (st == EN_ERS_WR && cnt == ERS_LAST);
  assign wr_fill = (st == EN_ERS_WR) ? '1 : '0;

  // R1
  start_enters_prefill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == EN_IDLE) |=> (st == EN_PRE_WR && idx == '0));

  // R4
  prefill_verified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_PRE_VF) |-> (vf_word == '0));

  // R4
  erase_after_prefill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_ERS_WR) |-> ($past(st) == EN_PRE_VF || $past(st) == EN_ERS_WR));

  // R3
  pre_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_PRE_WR) |-> (cnt < CW'(PRE_CLKS)));

  // R3
  ers_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_ERS_WR) |-> (cnt < CW'(ERS_CLKS)));

endmodule

// File: rtl/flash_ce_top.sv
module flash_ce_top
  import flash_ce_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 16,
  parameter int WORDS    = 16,
  parameter int PRE_CLKS = 4,
  parameter int ERS_CLKS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_oe,
  output logic [DW-1:0] bus_rdata,
  output logic          ready_busy_n
);

  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic          start_erase, prog_req, busy;
  logic [IW-1:0] prog_idx, eng_idx, arr_idx;
  logic [DW-1:0] prog_data, eng_fill, arr_data, host_word, vf_word;
  logic          eng_wr, arr_we, arr_and;
  logic          tog;
  logic [DW-1:0] status;

  flash_ce_cmd #(.AW(AW), .DW(DW), .IW(IW)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (bus_we),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .busy        (busy),
    .start_erase (start_erase),
    .prog_req    (prog_req),
    .prog_idx    (prog_idx),
    .prog_data   (prog_data)
  );

  flash_ce_engine #(
    .WORDS(WORDS), .DW(DW), .IW(IW), .PRE_CLKS(PRE_CLKS), .ERS_CLKS(ERS_CLKS)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_erase),
    .vf_word (vf_word),
    .busy    (busy),
    .idx     (eng_idx),
    .wr_en   (eng_wr),
    .wr_fill (eng_fill)
  );

  assign arr_we   = eng_wr | prog_req;
  assign arr_idx  = eng_wr ? eng_idx : prog_idx;
  assign arr_data = eng_wr ? eng_fill : prog_data;
  assign arr_and  = !eng_wr;

  flash_ce_array #(.WORDS(WORDS), .DW(DW), .IW(IW)) u_arr (
    .clk      (clk),
    .wr_en    (arr_we),
    .wr_idx   (arr_idx),
    .wr_data  (arr_data),
    .wr_and   (arr_and),
    .rd_idx_a (bus_addr[IW-1:0]),
    .rd_idx_b (eng_idx),
    .rd_a     (host_word),
    .rd_b     (vf_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tog <= 1'b0;
    else if (start_erase)   tog <= 1'b0;
    else if (busy && bus_oe) tog <= ~tog;
  end

  always_comb begin
    status    = '0;
    status[6] = tog;
    status[2] = tog;
  end

  assign bus_rdata    = !bus_oe ? '0 : (busy ? status : host_word);
  assign ready_busy_n = !busy;

  // R8
  status_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_oe && $past(busy && bus_oe)) |-> (bus_rdata[6] != $past(bus_rdata[6])));

  // R8
  status_bit7_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_busy_n && bus_oe) |-> (bus_rdata[7] == 1'b0));

  // R9
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_rdata == '0));

endmodule

// File: tb/tb_flash_ce_top.sv
`timescale 1ns/1ps
module tb_flash_ce_top;

  localparam int AW = 11, DW = 16, W = 8, PRE = 3, ERS = 5;
  localparam int BUSY_LEN = W * (PRE + 1) + W * ERS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic we = 1'b0, oe = 1'b0;
  logic [DW-1:0] rdata;
  logic ry;

  int total = 0, bad = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  flash_ce_top #(.AW(AW), .DW(DW), .WORDS(W), .PRE_CLKS(PRE), .ERS_CLKS(ERS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_oe(oe), .bus_rdata(rdata), .ready_busy_n(ry)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read strobe
  always @(negedge clk) begin
    if (oe) begin
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", rdata, 'x);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  function automatic logic [DW-1:0] pat(int i);
    return 16'h5A3C + DW'(i) * 16'h0101;
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string t);
    @(posedge clk); #1;
    addr = a; oe = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    oe = 1'b0;
  endtask

  task automatic erase_cmd();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0010);
  endtask

  task automatic prog_cmd(logic [AW-1:0] a, logic [DW-1:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
    wr(a, d);
  endtask

  // called right after erase_cmd returns; checks R3 onset and length
  task automatic count_busy(string t);
    int n = 0;
    @(negedge clk);
    check({t, " R3 still ready after final write"}, 16'(ry), 16'd1);
    forever begin
      @(negedge clk);
      if (!ry) n++;
      else break;
    end
    check({t, " R3 busy length"}, 16'(n), 16'(BUSY_LEN));
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!ry);
  endtask

  task automatic hw_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state, R9 quiet bus
    check("R12 ready after reset", 16'(ry), 16'd1);
    check("R9 rdata zero with oe low", rdata, 16'h0000);

    // R1 / R3 / R5 first full erase
    erase_cmd();
    count_busy("R1 erase");
    for (int i = 0; i < W; i++) rd(AW'(i), 16'hFFFF, "R5 erased word");

    // R10 program pattern, R11 reads
    for (int i = 0; i < W; i++) prog_cmd(AW'(i), pat(i));
    for (int i = 0; i < W; i++) rd(AW'(i), pat(i), "R11 program readback");
    prog_cmd(AW'(3), 16'h0FF0);
    rd(AW'(3), pat(3) & 16'h0FF0, "R10 program ANDs");
    rd(AW'(8 + 5), pat(5), "R11 high address bits ignored");

    // R2 broken sequences
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00AA);
    wr(11'h555, 16'h0080); wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h0010);
    repeat (3) @(negedge clk);
    check("R2 no erase after bad third write", 16'(ry), 16'd1);
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0);
    wr(11'h002, 16'h0000);
    repeat (3) @(negedge clk);
    check("R2 no erase after bad address", 16'(ry), 16'd1);
    rd(AW'(2), pat(2), "R2 word untouched by broken program");
    rd(AW'(3), pat(3) & 16'h0FF0, "R2 word untouched");

    // R8 status reads while busy
    erase_cmd();
    rd(AW'(0), 16'h0000, "R8 status first read");
    rd(AW'(1), 16'h0044, "R8 status second read");
    rd(AW'(2), 16'h0000, "R8 status third read");
    wait_ready();
    rd(AW'(4), 16'hFFFF, "R8 array visible after done");

    // R6 writes while busy are dropped
    erase_cmd();
    fork
      count_busy("R6");
      begin
        repeat (4) @(posedge clk);
        erase_cmd();
        prog_cmd(AW'(0), 16'h0000);
      end
    join
    for (int i = 0; i < W; i++) rd(AW'(i), 16'hFFFF, "R6 program ignored while busy");

    // R4 / R7 abort during zero-fill
    for (int i = 0; i < W; i++) prog_cmd(AW'(i), pat(i));
    erase_cmd();
    repeat (4 * (PRE + 1) + 2) @(negedge clk);
    hw_reset();
    @(negedge clk);
    check("R7 ready right after reset", 16'(ry), 16'd1);
    rd(AW'(0), 16'h0000, "R4 word0 zeroed before abort");
    rd(AW'(1), 16'h0000, "R4 word1 zeroed before abort");
    rd(AW'(W - 1), pat(W - 1), "R7 unreached word keeps data");
    erase_cmd();
    count_busy("R7 restart");
    for (int i = 0; i < W; i++) rd(AW'(i), 16'hFFFF, "R7 restart completes");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule